// File: doc/BRIEF.md
# TDM PCM Time-Slot Serial Port

This block is a four-channel serial port for a time-division-multiplexed PCM highway. A bit clock and a frame sync pulse share one serial bus. Every frame is cut into 8-bit slots that are counted from the frame sync. Each transmit channel and each receive channel has its own programmable slot number and its own enable. A transmit channel drives its sample byte onto the serial output during its slot, most significant bit first. At every other time the output enable stays low, so a pad buffer can hold the line in high impedance. A receive channel captures the byte that appears in its slot and presents it on a parallel output with a one-cycle valid strobe.

The block runs on a fast system clock. The bit clock, the frame sync and the serial input are sampled as inputs that are synchronous to that clock, and each bit-clock edge is found by comparing against the previous sample. Slot settings are loaded through a single-cycle parallel write port. The frame length is not fixed. It is simply the number of bit clocks between two frame syncs, which allows anything from 8 to 128 slots per frame.

Top module: `pcm_tdm_port`

## Requirements
- R1: After reset every slot setting is zero and every channel is disabled. `dx_oe`, `dx` and `rx_valid` are low, and nothing is driven or delivered until a channel is programmed.
- R2: A write with `wr_en` high loads one setting. `wr_addr[2]` selects the direction (0 transmit, 1 receive) and `wr_addr[1:0]` selects the channel. `wr_data[7]` is the enable and `wr_data[6:0]` is the slot number.
- R3: A channel takes part only when its enable bit is 1 and its slot number is not zero. An enabled channel with slot 0 stays silent.
- R4: The frame sync is sampled on each rising bit-clock edge. When it is high, the bit position becomes 0. On every other rising edge the position advances by one. The slot is the position divided by 8 and the bit is the position modulo 8.
- R5: Serial output bits change only in the system-clock cycle after a rising bit-clock edge is seen. A slot's byte is taken from `tx_data` at the slot's first bit and sent most significant bit first.
- R6: `dx_oe` is high for exactly the 8 bit periods of a live transmit channel's slot. At all other times it is low, and `dx` is then 0.
- R7: When several live transmit channels hold the same slot, the lowest-numbered channel drives it.
- R8: Serial input is sampled on each falling bit-clock edge, most significant bit first. After the eighth bit of a slot, every live receive channel that holds that slot gets the byte and a `rx_valid` pulse lasting one cycle.
- R9: A frame sync that arrives early restarts the count, so slots past the end of a short frame are never reached.
- R10: Before the first frame sync, and after 1024 rising bit-clock edges with no frame sync, the port is idle: no output and no delivery until the next frame sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Setting write strobe |
| wr_addr | input | 3 | Direction bit and channel number |
| wr_data | input | 8 | Enable bit and slot number |
| bclk | input | 1 | Serial bit clock, sampled by `clk` |
| fs | input | 1 | Frame sync, sampled on rising `bclk` |
| tx_data | input | 32 | Transmit bytes, channel c in bits 8c+7..8c |
| dx | output | 1 | Serial transmit data |
| dx_oe | output | 1 | Drive enable for `dx` |
| dr | input | 1 | Serial receive data |
| rx_data | output | 32 | Received bytes, channel c in bits 8c+7..8c |
| rx_valid | output | 4 | Per-channel byte strobe |

## Verification
Two receive channels that share a slot both finish the same byte on the same falling bit-clock edge, so two strobes fire in one cycle. The bench sets this up by giving receive channels 0 and 1 the same slot. The model queues two items for that slot, in channel order, and the monitor pops one for each asserted strobe bit in ascending order, comparing both the channel and the data. The transmit side has a matching collision: channels 1 and 2 share a slot. That case is judged bit by bit, against the byte of the lower channel.

// File: rtl/pcm_tdm_pkg.sv
package pcm_tdm_pkg;

  localparam int SLOT_W   = 7;
  localparam int SAMPLE_W = 8;
  localparam int BIT_W    = $clog2(SAMPLE_W);
  localparam int POS_W    = SLOT_W + BIT_W;
  localparam int CFG_W    = SLOT_W + 1;

  typedef struct packed {
    logic              en;
    logic [SLOT_W-1:0] slot;
  } lane_cfg_t;

  function automatic logic [SLOT_W-1:0] pos_slot(input logic [POS_W-1:0] p);
    return p[POS_W-1:BIT_W];
  endfunction

  function automatic logic [BIT_W-1:0] pos_bit(input logic [POS_W-1:0] p);
    return p[BIT_W-1:0];
  endfunction

  function automatic logic lane_live(input lane_cfg_t c);
    return c.en && (c.slot != '0);
  endfunction

  // serial order is MSB first: bit period b carries sample bit (SAMPLE_W-1-b)
  function automatic logic [BIT_W-1:0] wire_index(input logic [BIT_W-1:0] b);
    return BIT_W'(SAMPLE_W - 1) - b;
  endfunction

endpackage

// File: rtl/pcm_slot_regs.sv
module pcm_slot_regs
  import pcm_tdm_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CH_W:0]   wr_addr,
  input  logic [CFG_W-1:0] wr_data,
  output lane_cfg_t       tx_cfg [NUM_CH],
  output lane_cfg_t       rx_cfg [NUM_CH]
);

  logic            wr_rx;
  logic [CH_W-1:0] wr_ch;

  assign wr_rx = wr_addr[CH_W];
  assign wr_ch = wr_addr[CH_W-1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tx_cfg[c] <= '0;
      end else if (wr_en && !wr_rx && (wr_ch == CH_W'(c))) begin
        tx_cfg[c] <= lane_cfg_t'(wr_data);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rx_cfg[c] <= '0;
      end else if (wr_en && wr_rx && (wr_ch == CH_W'(c))) begin
        rx_cfg[c] <= lane_cfg_t'(wr_data);
      end
    end
  end

endmodule

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
  import pcm_tdm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk,
  input  logic             fs,
  output logic             bclk_rise,
  output logic             bclk_fall,
  output logic             launch,
  output logic             framed,
  output logic [POS_W-1:0] pos
);

  localparam logic [POS_W-1:0] POS_LAST = '1;

  logic bclk_d;

  assign bclk_rise = bclk & ~bclk_d;
  assign bclk_fall = ~bclk & bclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_d <= 1'b0;
      launch <= 1'b0;
    end else begin
      bclk_d <= bclk;
      launch <= bclk_rise;
    end
  end

  // position counter: restarts on frame sync, stops framing on overrun
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos    <= '0;
      framed <= 1'b0;
    end else if (bclk_rise) begin
      if (fs) begin
        pos    <= '0;
        framed <= 1'b1;
      end else if (framed) begin
        if (pos == POS_LAST) begin
          framed <= 1'b0;
        end else begin
          pos <= pos + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane
  import pcm_tdm_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       launch,
  input  logic                       framed,
  input  logic [POS_W-1:0]           pos,
  input  lane_cfg_t                  tx_cfg [NUM_CH],
  input  logic [NUM_CH*SAMPLE_W-1:0] tx_data,
  output logic                       tx_hit,
  output logic [CH_W-1:0]            tx_owner,
  output logic                       dx,
  output logic                       dx_oe
);

  logic [SAMPLE_W-1:0] hold_q;
  logic [SAMPLE_W-1:0] fresh;
  logic [BIT_W-1:0]    cur_bit;

  // priority pick: scan downward so the lowest channel is written last
  always_comb begin
    tx_hit   = 1'b0;
    tx_owner = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (lane_live(tx_cfg[c]) && (tx_cfg[c].slot == pos_slot(pos))) begin
        tx_hit   = 1'b1;
        tx_owner = CH_W'(c);
      end
    end
  end

  assign fresh   = tx_data[int'(tx_owner)*SAMPLE_W +: SAMPLE_W];
  assign cur_bit = pos_bit(pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      dx     <= 1'b0;
      dx_oe  <= 1'b0;
    end else if (launch) begin
      if (framed && tx_hit) begin
        dx_oe <= 1'b1;
        if (cur_bit == '0) begin
          hold_q <= fresh;
          dx     <= fresh[SAMPLE_W-1];
        end else begin
          dx     <= hold_q[wire_index(cur_bit)];
        end
      end else begin
        dx_oe <= 1'b0;
        dx    <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane
  import pcm_tdm_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       capture,
  input  logic                       framed,
  input  logic [POS_W-1:0]           pos,
  input  logic                       dr,
  input  lane_cfg_t                  rx_cfg [NUM_CH],
  output logic                       byte_done,
  output logic [NUM_CH-1:0]          rx_hit,
  output logic [NUM_CH*SAMPLE_W-1:0] rx_data,
  output logic [NUM_CH-1:0]          rx_valid
);

  logic [SAMPLE_W-2:0] shift_q;
  logic [SAMPLE_W-1:0] whole;
  logic [SAMPLE_W-1:0] data_q  [NUM_CH];
  logic                valid_q [NUM_CH];

  assign whole     = {shift_q, dr};
  assign byte_done = capture && framed && (pos_bit(pos) == BIT_W'(SAMPLE_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else if (capture) begin
      shift_q <= whole[SAMPLE_W-2:0];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign rx_hit[c] = lane_live(rx_cfg[c]) && (rx_cfg[c].slot == pos_slot(pos));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[c]  <= '0;
        valid_q[c] <= 1'b0;
      end else begin
        valid_q[c] <= byte_done && rx_hit[c];
        if (byte_done && rx_hit[c]) begin
          data_q[c] <= whole;
        end
      end
    end

    assign rx_data[c*SAMPLE_W +: SAMPLE_W] = data_q[c];
    assign rx_valid[c]                     = valid_q[c];
  end

endmodule

// File: rtl/pcm_tdm_port.sv
module pcm_tdm_port
  import pcm_tdm_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [CH_W:0]              wr_addr,
  input  logic [CFG_W-1:0]           wr_data,
  input  logic                       bclk,
  input  logic                       fs,
  input  logic [NUM_CH*SAMPLE_W-1:0] tx_data,
  output logic                       dx,
  output logic                       dx_oe,
  input  logic                       dr,
  output logic [NUM_CH*SAMPLE_W-1:0] rx_data,
  output logic [NUM_CH-1:0]          rx_valid
);

  // named internal events, visible to the bound checker
  lane_cfg_t        tx_cfg [NUM_CH];
  lane_cfg_t        rx_cfg [NUM_CH];
  logic             bclk_rise;
  logic             bclk_fall;
  logic             launch;
  logic             framed;
  logic [POS_W-1:0] pos;
  logic             tx_hit;
  logic [CH_W-1:0]  tx_owner;
  logic             byte_done;
  logic [NUM_CH-1:0] rx_hit;

  pcm_slot_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .tx_cfg  (tx_cfg),
    .rx_cfg  (rx_cfg)
  );

  pcm_frame_timer u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk      (bclk),
    .fs        (fs),
    .bclk_rise (bclk_rise),
    .bclk_fall (bclk_fall),
    .launch    (launch),
    .framed    (framed),
    .pos       (pos)
  );

  pcm_tx_lane #(.NUM_CH(NUM_CH)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .framed   (framed),
    .pos      (pos),
    .tx_cfg   (tx_cfg),
    .tx_data  (tx_data),
    .tx_hit   (tx_hit),
    .tx_owner (tx_owner),
    .dx       (dx),
    .dx_oe    (dx_oe)
  );

  pcm_rx_lane #(.NUM_CH(NUM_CH)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (bclk_fall),
    .framed    (framed),
    .pos       (pos),
    .dr        (dr),
    .rx_cfg    (rx_cfg),
    .byte_done (byte_done),
    .rx_hit    (rx_hit),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid)
  );

endmodule

// File: rtl/pcm_tdm_port_sva.sv
module pcm_tdm_port_sva
  import pcm_tdm_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bclk_rise,
  input logic              bclk_fall,
  input logic              launch,
  input logic              fs,
  input logic              framed,
  input logic [POS_W-1:0]  pos,
  input logic              tx_hit,
  input logic              dx,
  input logic              dx_oe,
  input logic [NUM_CH-1:0] rx_valid,
  input lane_cfg_t         rx_cfg [NUM_CH]
);

  // R4: a sampled frame sync lands on position zero and opens a frame
  p_sync_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bclk_rise && fs) |-> (pos == '0) && framed);

  // R4: the two bit-clock edges are never seen together
  p_edge_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bclk_rise && bclk_fall));

  // R5: serial data moves only right after a rising edge
  p_dx_on_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dx) |-> $past(launch));

  // R6: drive enable moves only right after a rising edge
  p_oe_on_launch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dx_oe) |-> $past(launch));

  // R6: an idle line carries zero
  p_dx_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !dx_oe |-> !dx);

  // R10: driving starts only inside a frame on an owned slot
  p_oe_needs_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dx_oe) |-> $past(framed && tx_hit));

  // R8: a strobe follows a falling edge that closed a byte in frame
  p_valid_after_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|rx_valid) |-> $past(bclk_fall && framed && (pos_bit(pos) == BIT_W'(SAMPLE_W - 1))));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // R8: each strobe lasts a single cycle
    p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid[c] |=> !rx_valid[c]);

    // R3: only a live channel ever strobes
    p_valid_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid[c] |-> $past(rx_cfg[c].en && (rx_cfg[c].slot != '0)));
  end

endmodule

bind pcm_tdm_port pcm_tdm_port_sva #(.NUM_CH(NUM_CH)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .bclk_rise (bclk_rise),
  .bclk_fall (bclk_fall),
  .launch    (launch),
  .fs        (fs),
  .framed    (framed),
  .pos       (pos),
  .tx_hit    (tx_hit),
  .dx        (dx),
  .dx_oe     (dx_oe),
  .rx_valid  (rx_valid),
  .rx_cfg    (rx_cfg)
);

// File: tb/pcm_tdm_port_bench.sv
module pcm_tdm_port_bench;

  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        bclk = 1'b0;
  logic        fs = 1'b0;
  logic [31:0] tx_data = '0;
  logic        dr = 1'b0;
  logic        dx;
  logic        dx_oe;
  logic [31:0] rx_data;
  logic [3:0]  rx_valid;

  pcm_tdm_port #(.NUM_CH(NCH)) u_pcm_tdm_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .bclk(bclk), .fs(fs), .tx_data(tx_data), .dx(dx), .dx_oe(dx_oe), .dr(dr),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );

  always #4 clk = ~clk;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct { int ch; logic [7:0] b; } rx_item_t;
  rx_item_t exp_q [$];

  // bench model state
  int         m_tx_en [NCH];
  int         m_tx_slot [NCH];
  int         m_rx_en [NCH];
  int         m_rx_slot [NCH];
  int         bpos;
  bit         bframed;
  logic [7:0] win;
  logic [15:0] lfsr = 16'hACE1;
  string      tag = "R1";

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  function automatic bit live(input int en, input int slot);
    return (en != 0) && (slot != 0);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bclk = 1'b0; fs = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < NCH; c++) begin
      m_tx_en[c] = 0; m_tx_slot[c] = 0; m_rx_en[c] = 0; m_rx_slot[c] = 0;
    end
    bpos = 0; bframed = 1'b0; win = '0;
    exp_q.delete();
  endtask

  // R2: address bit 2 = direction (0 tx, 1 rx), bits 1:0 channel; data bit 7 enable, 6:0 slot
  task automatic set_lane(input bit rx, input int ch, input int en, input int slot);
    @(negedge clk);
    wr_en = 1'b1;
    wr_addr = {rx, 2'(ch)};
    wr_data = {1'(en), 7'(slot)};
    @(negedge clk);
    wr_en = 1'b0;
    if (rx) begin m_rx_en[ch] = en; m_rx_slot[ch] = slot; end
    else    begin m_tx_en[ch] = en; m_tx_slot[ch] = slot; end
  endtask

  task automatic step_bit(input bit fs_v);
    bit         dr_v;
    int         slot, bitn, owner;
    logic       e_oe, e_dx;
    dr_v = lfsr[0];
    lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    @(negedge clk);
    bclk = 1'b1; fs = fs_v; dr = dr_v;
    // model of R4/R9/R10 position tracking
    if (fs_v) begin bpos = 0; bframed = 1'b1; end
    else if (bframed) begin
      if (bpos == 1023) bframed = 1'b0;
      else bpos++;
    end
    slot = bpos / 8; bitn = bpos % 8;
    owner = -1;
    if (bframed)
      for (int c = NCH - 1; c >= 0; c--)
        if (live(m_tx_en[c], m_tx_slot[c]) && m_tx_slot[c] == slot) owner = c;
    e_oe = (owner >= 0);
    e_dx = e_oe ? tx_data[owner*8 + (7 - bitn)] : 1'b0;
    win = {win[6:0], dr_v};
    if (bframed && bitn == 7)
      for (int c = 0; c < NCH; c++)
        if (live(m_rx_en[c], m_rx_slot[c]) && m_rx_slot[c] == slot) begin
          rx_item_t it;
          it.ch = c; it.b = win;
          exp_q.push_back(it);
        end
    repeat (3) @(negedge clk);
    chk({tag, " R6 oe"}, 32'(dx_oe), 32'(e_oe));
    chk({tag, " R5 dx"}, 32'(dx), 32'(e_dx));
    bclk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_bits(input int n, input bit with_fs);
    for (int p = 0; p < n; p++) step_bit(with_fs && (p == 0));
  endtask

  // scoreboard monitor for the receive strobes (R8)
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        if (rx_valid[c]) begin
          if (exp_q.size() == 0) begin
            chk("R8 unexpected strobe ch", 32'(c), 32'hFFFF);
          end else begin
            rx_item_t it;
            it = exp_q.pop_front();
            chk("R8 strobe channel", 32'(c), 32'(it.ch));
            chk("R8 strobe data", 32'(rx_data[c*8 +: 8]), 32'(it.b));
          end
        end
      end
    end
  end

  task automatic drain_check(input string t);
    repeat (4) @(negedge clk);
    chk({t, " R8 pending items"}, 32'(exp_q.size()), 32'd0);
    exp_q.delete();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    do_reset();
    // R1: reset state at the ports
    chk("R1 oe after reset", 32'(dx_oe), 32'd0);
    chk("R1 dx after reset", 32'(dx), 32'd0);
    chk("R1 strobes after reset", 32'(rx_valid), 32'd0);

    // R1: unprogrammed port ignores a full frame
    tag = "R1";
    tx_data = 32'hA5C3_3C5A;
    run_bits(32, 1'b1);
    drain_check("R1");

    // R10: programmed but never framed stays idle
    do_reset();
    tag = "R2 R3 R7";
    set_lane(1'b0, 0, 1, 1);
    set_lane(1'b0, 1, 1, 3);
    set_lane(1'b0, 2, 1, 3);   // same slot as ch1: ch1 wins (R7)
    set_lane(1'b0, 3, 1, 0);   // slot 0: disabled (R3)
    set_lane(1'b1, 0, 1, 2);
    set_lane(1'b1, 1, 1, 2);   // shares slot with rx ch0
    set_lane(1'b1, 2, 0, 5);   // enable clear (R3)
    set_lane(1'b1, 3, 1, 0);   // slot 0 (R3)
    tx_data = 32'h96_E1_4B_D2;
    tag = "R10 no sync";
    run_bits(24, 1'b0);
    drain_check("R10");

    // R3 R4 R7 R8: full 8-slot frame
    tag = "R4 R7";
    run_bits(64, 1'b1);
    drain_check("R3 R4");

    // R9: short frame cut by an early sync, then a regular frame
    tag = "R9";
    tx_data = 32'h0F_F0_81_7E;
    run_bits(20, 1'b1);
    set_lane(1'b0, 2, 1, 6);
    set_lane(1'b1, 3, 1, 7);
    run_bits(64, 1'b1);
    drain_check("R9");

    // R4 R10: top slot in a 128-slot frame, then overrun with no sync
    tag = "R4 top slot";
    set_lane(1'b0, 3, 1, 127);
    set_lane(1'b1, 2, 1, 127);
    tx_data = 32'h5A_C3_99_24;
    run_bits(1024, 1'b1);
    tag = "R10 overrun";
    run_bits(16, 1'b0);
    drain_check("R10 overrun");

    // R10: a fresh sync restores operation
    tag = "R10 recover";
    run_bits(64, 1'b1);
    drain_check("R10 recover");

    finish_run();
  end

endmodule